// File: doc/BRIEF.md
# Flash Page Transfer Sequencer

This block is a bus-master state machine that carries out one hardware page transfer on a flash controller and then reports what happened. A single start pulse launches the transfer. The start pulse carries a direction bit and a page number. The sequencer then issues a fixed series of register writes over a simple valid/ready register port. It hands the shared pads to the controller, programs the page and a zero column, and fires the command. It waits for the DMA engine to signal completion and polls the controller's ready flag. In every case it gives the pads back to raw mode.

After a successful read, the block fetches the transfer status word. If the page turned out to be blank, it reports zero bitflips at once. Otherwise it fetches the ECC report word, which summarises two packet groups. It then returns either an uncorrectable flag or the larger of the two error counts. The sum of the two counts is added to a running corrected-bit total. The DMA engine, the flash device and the ECC codec sit outside the block.

Top module: `nand_xfer_seq`

## Requirements
- R1: After reset the block issues no bus request (bus_valid_o low) and no result (res_valid_o low), and corr_total_o reads 0.
- R2: While bus_valid_o is high and bus_ready_i is low, bus_valid_o, bus_we_o, bus_addr_o and bus_wdata_o hold steady. An access completes in the cycle where both are high, and read data is taken from bus_rdata_i in that same cycle.
- R3: A transfer performs these writes in this exact order. First, address 0x40 (pad mode) receives 0x8000_0000, which selects controller mode. Next, address 0x08 (page) receives page_i. Then address 0x0C (column) receives 0. Last, address 0x10 (command) receives 1 for a read (write_i=0) or 2 for a write (write_i=1).
- R4: A write transfer first writes 0xFFFF_FFFF to address 0x80 (first metadata word), before the pad-mode write. A read transfer never touches 0x80.
- R5: After the command write, the block waits for a one-cycle dma_done_i pulse. It then reads address 0x00 until bit 31 (ready) is set. If POLL_MAX reads in a row come back not ready, the transfer ends with code 1 (timeout).
- R6: If dma_done_i does not arrive within DMA_WAIT_MAX cycles of waiting, the transfer ends with code 1 (timeout) and address 0x00 is never read.
- R7: Every transfer, whether it succeeds or times out, writes 0 to address 0x40 (raw pad mode) after the completion phase and before the result appears.
- R8: After a read that did not time out, the block reads the transfer status at 0x04. If bit 16 (blank page) is set, the result is code 0 with 0 bitflips, address 0x84 is not read, and the total is unchanged.
- R9: Otherwise the block reads the ECC report at 0x84. Bits [5:0] hold the count for the first packet and bits [13:8] hold the count for the remaining packets. Bit 7 and bit 15 are the matching success flags. When both flags are set, the result is code 0 and res_flips_o equals the larger count. In that case corr_total_o grows by the sum of the two counts, wrapping at 2^TOTAL_W.
- R10: If either success flag is clear, the result is code 2 (uncorrectable) with res_flips_o = 0, and corr_total_o is unchanged.
- R11: Each transfer produces exactly one res_valid_o pulse, one cycle long. The bus is idle in the following cycle. Writes and timeouts report 0 bitflips and read neither 0x04 nor 0x84.
- R12: A start_i pulse that arrives while a transfer is in progress is ignored. It causes no extra bus access and no extra result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start one transfer (taken only when idle) |
| write_i | input | 1 | Direction with start: 1 write, 0 read |
| page_i | input | 32 | Page number with start |
| dma_done_i | input | 1 | One-cycle DMA completion pulse |
| bus_valid_o | output | 1 | Register access request |
| bus_we_o | output | 1 | 1 write, 0 read |
| bus_addr_o | output | ADDR_W | Register address |
| bus_wdata_o | output | 32 | Write data |
| bus_ready_i | input | 1 | Access accepted this cycle |
| bus_rdata_i | input | 32 | Read data, valid with bus_ready_i |
| res_valid_o | output | 1 | Result strobe, one cycle per transfer |
| res_code_o | output | 2 | 0 ok, 1 timeout, 2 uncorrectable |
| res_flips_o | output | 6 | Bitflip result |
| corr_total_o | output | TOTAL_W | Running corrected-bit total |

## Verification
The bench targets the following corner cases:

- **Count ordering.** Reports where the first packet's count is the larger one, and reports where the other count is larger. A design that always picks one field, or that takes the sum as the bitflip result, returns the wrong value.
- **Maximum counts.** Both counts at 63, which exposes a sum that is too narrow.
- **Each success flag on its own.** Reports with only one flag clear. A decoder that checks just one flag would pass a failed decode as corrected.
- **Timeouts.** A lost DMA pulse, and a ready flag that never rises. A design that skips the raw-mode write on those paths leaves the pads with the controller.
- **Other paths.** A blank page, a write, and a start pulse in the middle of a transfer. These expose, respectively, a stray ECC read, a missing metadata fill, and a second command sequence.
- **Bus stalls.** Stalls on the ready line, which catch request fields that change before acceptance.

// File: rtl/nxs_pkg.sv
package nxs_pkg;

  // Register map used by the sequencer (byte addresses)
  localparam int unsigned A_STATUS = 'h00;
  localparam int unsigned A_XSTAT  = 'h04;
  localparam int unsigned A_PAGE   = 'h08;
  localparam int unsigned A_COLUMN = 'h0C;
  localparam int unsigned A_CMD    = 'h10;
  localparam int unsigned A_PAD    = 'h40;
  localparam int unsigned A_META   = 'h80;
  localparam int unsigned A_ECCREP = 'h84;

  localparam logic [31:0] PAD_CTRL = 32'h8000_0000;
  localparam logic [31:0] PAD_RAW  = 32'h0000_0000;
  localparam logic [31:0] OP_READ  = 32'd1;
  localparam logic [31:0] OP_WRITE = 32'd2;

  localparam int unsigned READY_BIT = 31;
  localparam int unsigned BLANK_BIT = 16;

  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_TIMEOUT = 2'd1,
    RES_UNCORR  = 2'd2
  } res_code_t;

  typedef enum logic [3:0] {
    S_IDLE, S_META, S_PADON, S_PAGE, S_COL, S_CMD,
    S_DMA, S_POLL, S_PADOFF, S_XSTAT, S_ECC, S_DONE
  } seq_state_t;

  typedef struct packed {
    logic       unc;
    logic [5:0] worst;
    logic [6:0] sum;
  } ecc_fold_t;

  // Fold a two-group ECC report into a single verdict
  function automatic ecc_fold_t ecc_fold(input logic [31:0] rep);
    ecc_fold_t  r;
    logic [5:0] c_first;
    logic [5:0] c_rest;
    c_first = rep[5:0];
    c_rest  = rep[13:8];
    r.unc   = ~(rep[7] & rep[15]);
    r.worst = (c_first > c_rest) ? c_first : c_rest;
    r.sum   = {1'b0, c_first} + {1'b0, c_rest};
    return r;
  endfunction

endpackage

// File: rtl/nxs_limit_cnt.sv
module nxs_limit_cnt #(
  parameter int unsigned LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic hit_o
);
  localparam int unsigned W = $clog2(LIMIT + 1);

  logic [W-1:0] cnt_q;

  // hit on the LIMIT-th increment since the last clear
  assign hit_o = inc_i && (cnt_q == W'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/nxs_ecc_merge.sv
module nxs_ecc_merge
  import nxs_pkg::*;
(
  input  logic [31:0] report_i,
  output logic        unc_o,
  output logic [5:0]  worst_o,
  output logic [6:0]  sum_o
);
  ecc_fold_t f;
  always_comb begin
    f       = ecc_fold(report_i);
    unc_o   = f.unc;
    worst_o = f.worst;
    sum_o   = f.sum;
  end
endmodule

// File: rtl/nand_xfer_seq.sv
module nand_xfer_seq
  import nxs_pkg::*;
#(
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned DMA_WAIT_MAX = 1024,
  parameter int unsigned POLL_MAX     = 64,
  parameter int unsigned TOTAL_W      = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               write_i,
  input  logic [31:0]        page_i,
  input  logic               dma_done_i,
  output logic               bus_valid_o,
  output logic               bus_we_o,
  output logic [ADDR_W-1:0]  bus_addr_o,
  output logic [31:0]        bus_wdata_o,
  input  logic               bus_ready_i,
  input  logic [31:0]        bus_rdata_i,
  output logic               res_valid_o,
  output logic [1:0]         res_code_o,
  output logic [5:0]         res_flips_o,
  output logic [TOTAL_W-1:0] corr_total_o
);

  seq_state_t         state_q, state_d;
  logic               is_wr_q;
  logic [31:0]        page_q;
  res_code_t          code_q;
  logic [5:0]         flips_q;
  logic [TOTAL_W-1:0] total_q;

  // named internal events
  logic ev_fire, ev_accept, ev_ready_seen, ev_poll_miss, ev_dma_wait;
  logic dma_expired, poll_expired;
  logic ecc_unc;
  logic [5:0] ecc_worst;
  logic [6:0] ecc_sum;

  assign ev_fire       = bus_valid_o & bus_ready_i;
  assign ev_accept     = start_i & (state_q == S_IDLE);
  assign ev_ready_seen = (state_q == S_POLL) & ev_fire & bus_rdata_i[READY_BIT];
  assign ev_poll_miss  = (state_q == S_POLL) & ev_fire & ~bus_rdata_i[READY_BIT];
  assign ev_dma_wait   = (state_q == S_DMA) & ~dma_done_i;

  nxs_limit_cnt #(.LIMIT(DMA_WAIT_MAX)) dma_tmr_i (
    .clk(clk), .rst_n(rst_n), .clr_i(state_q != S_DMA),
    .inc_i(ev_dma_wait), .hit_o(dma_expired)
  );

  nxs_limit_cnt #(.LIMIT(POLL_MAX)) poll_tmr_i (
    .clk(clk), .rst_n(rst_n), .clr_i(state_q != S_POLL),
    .inc_i(ev_poll_miss), .hit_o(poll_expired)
  );

  nxs_ecc_merge ecc_i (
    .report_i(bus_rdata_i), .unc_o(ecc_unc),
    .worst_o(ecc_worst), .sum_o(ecc_sum)
  );

  // bus request decode per state
  always_comb begin
    bus_valid_o = 1'b0;
    bus_we_o    = 1'b0;
    bus_addr_o  = '0;
    bus_wdata_o = '0;
    unique case (state_q)
      S_META:   begin bus_valid_o = 1'b1; bus_we_o = 1'b1; bus_addr_o = ADDR_W'(A_META);   bus_wdata_o = 32'hFFFF_FFFF; end
      S_PADON:  begin bus_valid_o = 1'b1; bus_we_o = 1'b1; bus_addr_o = ADDR_W'(A_PAD);    bus_wdata_o = PAD_CTRL; end
      S_PAGE:   begin bus_valid_o = 1'b1; bus_we_o = 1'b1; bus_addr_o = ADDR_W'(A_PAGE);   bus_wdata_o = page_q; end
      S_COL:    begin bus_valid_o = 1'b1; bus_we_o = 1'b1; bus_addr_o = ADDR_W'(A_COLUMN); bus_wdata_o = '0; end
      S_CMD:    begin bus_valid_o = 1'b1; bus_we_o = 1'b1; bus_addr_o = ADDR_W'(A_CMD);    bus_wdata_o = is_wr_q ? OP_WRITE : OP_READ; end
      S_POLL:   begin bus_valid_o = 1'b1; bus_addr_o = ADDR_W'(A_STATUS); end
      S_PADOFF: begin bus_valid_o = 1'b1; bus_we_o = 1'b1; bus_addr_o = ADDR_W'(A_PAD);    bus_wdata_o = PAD_RAW; end
      S_XSTAT:  begin bus_valid_o = 1'b1; bus_addr_o = ADDR_W'(A_XSTAT); end
      S_ECC:    begin bus_valid_o = 1'b1; bus_addr_o = ADDR_W'(A_ECCREP); end
      default:  ;
    endcase
  end

  // next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:   if (start_i) state_d = write_i ? S_META : S_PADON;
      S_META:   if (ev_fire) state_d = S_PADON;
      S_PADON:  if (ev_fire) state_d = S_PAGE;
      S_PAGE:   if (ev_fire) state_d = S_COL;
      S_COL:    if (ev_fire) state_d = S_CMD;
      S_CMD:    if (ev_fire) state_d = S_DMA;
      S_DMA:    if (dma_done_i) state_d = S_POLL;
                else if (dma_expired) state_d = S_PADOFF;
      S_POLL:   if (ev_ready_seen || poll_expired) state_d = S_PADOFF;
      S_PADOFF: if (ev_fire) state_d = (is_wr_q || code_q != RES_OK) ? S_DONE : S_XSTAT;
      S_XSTAT:  if (ev_fire) state_d = bus_rdata_i[BLANK_BIT] ? S_DONE : S_ECC;
      S_ECC:    if (ev_fire) state_d = S_DONE;
      S_DONE:   state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      is_wr_q <= 1'b0;
      page_q  <= '0;
      code_q  <= RES_OK;
      flips_q <= '0;
      total_q <= '0;
    end else begin
      state_q <= state_d;
      if (ev_accept) begin
        is_wr_q <= write_i;
        page_q  <= page_i;
        code_q  <= RES_OK;
        flips_q <= '0;
      end
      if ((ev_dma_wait && dma_expired) || poll_expired)
        code_q <= RES_TIMEOUT;
      if (state_q == S_ECC && ev_fire) begin
        if (ecc_unc) begin
          code_q <= RES_UNCORR;
        end else begin
          flips_q <= ecc_worst;
          total_q <= total_q + TOTAL_W'(ecc_sum);
        end
      end
    end
  end

  assign res_valid_o  = (state_q == S_DONE);
  assign res_code_o   = code_q;
  assign res_flips_o  = flips_q;
  assign corr_total_o = total_q;

endmodule

// File: rtl/nxs_checker.sv
module nxs_checker
  import nxs_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned TOTAL_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_valid,
  input logic               bus_ready,
  input logic               bus_we,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [31:0]        bus_wdata,
  input logic               res_valid,
  input logic [1:0]         res_code,
  input logic [5:0]         res_flips,
  input logic [TOTAL_W-1:0] total
);
  logic              wr_fire;
  logic [ADDR_W-1:0] last_addr;
  logic [31:0]       last_data;

  assign wr_fire = bus_valid & bus_ready & bus_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_addr <= '0;
      last_data <= '0;
    end else if (wr_fire) begin
      last_addr <= bus_addr;
      last_data <= bus_wdata;
    end
  end

  // R1: quiet right after reset
  a_r1_idle_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !bus_valid && !res_valid);

  // R2: request held until accepted
  a_r2_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

  // R3: write ordering
  a_r3_page_after_pad: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire && bus_addr == ADDR_W'(A_PAGE) |-> last_addr == ADDR_W'(A_PAD) && last_data == PAD_CTRL);
  a_r3_col_after_page: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire && bus_addr == ADDR_W'(A_COLUMN) |-> last_addr == ADDR_W'(A_PAGE) && bus_wdata == '0);
  a_r3_cmd_after_col: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire && bus_addr == ADDR_W'(A_CMD) |-> last_addr == ADDR_W'(A_COLUMN));

  // R7: pads back in raw mode when the result appears
  a_r7_raw_before_result: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> last_addr == ADDR_W'(A_PAD) && last_data == PAD_RAW);

  // R10: uncorrectable reports zero flips
  a_r10_unc_zero: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_code == RES_UNCORR |-> res_flips == '0);

  // R9: total moves only with a good result
  a_r9_total_on_ok: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(total) |-> res_valid && res_code == RES_OK);

  // R11: single-cycle strobe, bus idle afterwards
  a_r11_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid && !bus_valid);
endmodule

bind nand_xfer_seq nxs_checker #(.ADDR_W(ADDR_W), .TOTAL_W(TOTAL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid_o), .bus_ready(bus_ready_i),
  .bus_we(bus_we_o), .bus_addr(bus_addr_o), .bus_wdata(bus_wdata_o),
  .res_valid(res_valid_o), .res_code(res_code_o), .res_flips(res_flips_o),
  .total(corr_total_o)
);

// File: tb/nand_xfer_seq_tb_top.sv
module nand_xfer_seq_tb_top;
  localparam int AW    = 8;
  localparam int DMAX  = 40;
  localparam int PMAX  = 6;
  localparam int TW    = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0, write_i = 1'b0, dma_done_i = 1'b0;
  logic [31:0]   page_i = '0;
  logic          bus_valid_o, bus_we_o, bus_ready_i = 1'b0;
  logic [AW-1:0] bus_addr_o;
  logic [31:0]   bus_wdata_o, bus_rdata_i;
  logic          res_valid_o;
  logic [1:0]    res_code_o;
  logic [5:0]    res_flips_o;
  logic [TW-1:0] corr_total_o;

  always #2 clk = ~clk; // 250 MHz

  nand_xfer_seq #(.ADDR_W(AW), .DMA_WAIT_MAX(DMAX), .POLL_MAX(PMAX), .TOTAL_W(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .write_i(write_i), .page_i(page_i),
    .dma_done_i(dma_done_i), .bus_valid_o(bus_valid_o), .bus_we_o(bus_we_o),
    .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o), .bus_ready_i(bus_ready_i),
    .bus_rdata_i(bus_rdata_i), .res_valid_o(res_valid_o), .res_code_o(res_code_o),
    .res_flips_o(res_flips_o), .corr_total_o(corr_total_o)
  );

  int checks = 0, fails = 0, res_seen = 0;
  bit finished = 0;

  // scenario knobs set by the driver
  int          dma_delay = 1, poll_need = 0;
  bit          stall = 0;
  logic [31:0] xstat_v = '0, ecc_v = '0;

  // slave model state
  int dma_cnt = 0, poll_seen = 0;

  // scoreboard queues
  logic          exp_we[$];
  logic [AW-1:0] exp_addr[$];
  logic [31:0]   exp_data[$];
  string         exp_tag[$];
  logic          obs_we[$];
  logic [AW-1:0] obs_addr[$];
  logic [31:0]   obs_data[$];
  logic [1:0]    xr_code[$];
  logic [5:0]    xr_flips[$];
  logic [TW-1:0] xr_total[$];
  string         xr_tag[$];
  logic [TW-1:0] tb_total = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always_comb begin
    case (bus_addr_o)
      8'h00:   bus_rdata_i = (poll_seen >= poll_need) ? 32'h8000_0000 : 32'h0000_1234;
      8'h04:   bus_rdata_i = xstat_v;
      8'h84:   bus_rdata_i = ecc_v;
      default: bus_rdata_i = 32'hDEAD_0000;
    endcase
  end

  // bus slave and DMA model
  always @(posedge clk) begin
    bus_ready_i <= stall ? ~bus_ready_i : 1'b1;
    if (rst_n && bus_valid_o && bus_ready_i) begin
      obs_we.push_back(bus_we_o);
      obs_addr.push_back(bus_addr_o);
      obs_data.push_back(bus_we_o ? bus_wdata_o : 32'h0);
      if (!bus_we_o && bus_addr_o == 8'h00) poll_seen <= poll_seen + 1;
      if (bus_we_o && bus_addr_o == 8'h10) poll_seen <= 0;
    end
    if (rst_n && bus_valid_o && bus_ready_i && bus_we_o && bus_addr_o == 8'h10 && dma_delay > 0)
      dma_cnt <= dma_delay;
    else if (dma_cnt > 0)
      dma_cnt <= dma_cnt - 1;
    dma_done_i <= (dma_cnt == 1);
  end

  // monitor
  always @(negedge clk) begin
    while (obs_we.size() > 0) begin
      logic w; logic [AW-1:0] a; logic [31:0] d;
      w = obs_we.pop_front(); a = obs_addr.pop_front(); d = obs_data.pop_front();
      if (exp_we.size() == 0) begin
        chk(1'b0, "R12", "unexpected bus access addr", {56'h0, a}, 64'h0);
      end else begin
        logic ew; logic [AW-1:0] ea; logic [31:0] ed; string t;
        ew = exp_we.pop_front(); ea = exp_addr.pop_front();
        ed = exp_data.pop_front(); t = exp_tag.pop_front();
        chk(w == ew && a == ea && d == ed, t, "bus access {we,addr,data}",
            {23'h0, w, a, d}, {23'h0, ew, ea, ed});
      end
    end
    if (rst_n && res_valid_o) begin
      res_seen++;
      if (xr_code.size() == 0) begin
        chk(1'b0, "R11", "unexpected result", {62'h0, res_code_o}, 64'h0);
      end else begin
        logic [1:0] ec; logic [5:0] ef; logic [TW-1:0] et; string t;
        ec = xr_code.pop_front(); ef = xr_flips.pop_front();
        et = xr_total.pop_front(); t = xr_tag.pop_front();
        chk(res_code_o == ec && res_flips_o == ef && corr_total_o == et, t,
            "result {code,flips,total}", {40'h0, res_code_o, res_flips_o, corr_total_o},
            {40'h0, ec, ef, et});
      end
    end
  end

  task automatic exp_op(input logic w, input int a, input logic [31:0] d, input string t);
    exp_we.push_back(w); exp_addr.push_back(AW'(a)); exp_data.push_back(d); exp_tag.push_back(t);
  endtask

  task automatic run(input bit wr, input logic [31:0] pg, input int dly, input int pneed,
                     input logic [31:0] xs, input logic [31:0] ec, input bit stl,
                     input bit extra, input string tag);
    bit to; logic [1:0] rc; logic [5:0] rf; int target;
    @(negedge clk);
    dma_delay = dly; poll_need = pneed; xstat_v = xs; ecc_v = ec; stall = stl;
    to = 0; rc = 2'd0; rf = 6'd0;
    if (wr) exp_op(1, 'h80, 32'hFFFF_FFFF, "R4");
    exp_op(1, 'h40, 32'h8000_0000, "R3");
    exp_op(1, 'h08, pg, "R3");
    exp_op(1, 'h0C, 32'h0, "R3");
    exp_op(1, 'h10, wr ? 32'd2 : 32'd1, "R3");
    if (dly == 0) begin
      to = 1;
    end else begin
      int n = (pneed < PMAX) ? pneed + 1 : PMAX;
      for (int i = 0; i < n; i++) exp_op(0, 'h00, 32'h0, "R5");
      if (pneed >= PMAX) to = 1;
    end
    exp_op(1, 'h40, 32'h0, "R7");
    if (to) rc = 2'd1;
    else if (!wr) begin
      exp_op(0, 'h04, 32'h0, "R8");
      if (((xs >> 16) & 1) == 0) begin
        int a0 = ec & 'h3F; int a1 = (ec >> 8) & 'h3F;
        exp_op(0, 'h84, 32'h0, "R9");
        if (((ec >> 7) & 1) == 0 || ((ec >> 15) & 1) == 0) rc = 2'd2;
        else begin
          rf = 6'((a1 >= a0) ? a1 : a0);
          tb_total = tb_total + TW'(a0 + a1);
        end
      end
    end
    xr_code.push_back(rc); xr_flips.push_back(rf); xr_total.push_back(tb_total); xr_tag.push_back(tag);
    target = res_seen + 1;
    start_i = 1; write_i = wr; page_i = pg;
    @(negedge clk);
    start_i = 0;
    if (extra) begin
      repeat (3) @(negedge clk);
      start_i = 1; write_i = 1; page_i = 32'h0BAD_0BAD;
      @(negedge clk);
      start_i = 0;
    end
    while (res_seen < target) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(exp_we.size() == 0 && res_seen == target, tag, "pending accesses after result",
        64'(exp_we.size()), 64'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!bus_valid_o && !res_valid_o && corr_total_o == '0, "R1", "idle after reset",
        {62'h0, bus_valid_o, res_valid_o}, 64'h0);
    // R9: second count larger, first count larger, stalls on ready (R2)
    run(0, 32'h0000_0102, 3, 0, 32'h0, 32'h0000_8583, 0, 0, "R9");
    run(0, 32'h00AB_CDEF, 5, 1, 32'h0, 32'h0000_8289, 1, 0, "R9");
    run(0, 32'h0000_0007, 2, 0, 32'h0, 32'h0000_8A84, 1, 0, "R2");
    // R8: blank page
    run(0, 32'h0000_0010, 2, 0, 32'h0001_0000, 32'h0000_FFFF, 0, 0, "R8");
    // R10: each success flag clear alone
    run(0, 32'h0000_0011, 2, 0, 32'h0, 32'h0000_0385, 0, 0, "R10");
    run(0, 32'h0000_0012, 2, 0, 32'h0, 32'h0000_8503, 0, 0, "R10");
    // R4 / R11: write transfer
    run(1, 32'h0000_0020, 4, 2, 32'h0, 32'h0, 0, 0, "R4");
    // R5: delayed ready, then ready never rising
    run(0, 32'h0000_0030, 2, 3, 32'h0, 32'h0000_8180, 0, 0, "R5");
    run(0, 32'h0000_0031, 2, 100, 32'h0, 32'h0, 1, 0, "R5");
    // R6: DMA pulse never arrives
    run(0, 32'h0000_0040, 0, 0, 32'h0, 32'h0, 0, 0, "R6");
    run(1, 32'h0000_0041, 0, 0, 32'h0, 32'h0, 0, 0, "R6");
    // R12: start during a transfer
    run(0, 32'h0000_0050, 6, 1, 32'h0, 32'h0000_8101, 0, 1, "R12");
    // R9: both counts at maximum
    run(0, 32'h0000_0060, 2, 0, 32'h0, 32'h0000_BFBF, 0, 0, "R9");
    chk(corr_total_o == tb_total, "R9", "final total", 64'(corr_total_o), 64'(tb_total));
    chk(!res_valid_o && !bus_valid_o, "R11", "idle at end", {62'h0, res_valid_o, bus_valid_o}, 64'h0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule